// File: doc/BRIEF.md
# Auto-Negotiation Parallel Detection Resolver

This block works next to an Ethernet auto-negotiation arbiter. It completes link setup when the link partner cannot negotiate but sends a legacy link signal that the 10 Mb/s or the 100 Mb/s receiver accepts. It watches one abstract link-good flag for each technology. A flag must hold for a programmable number of clock cycles before it counts as a good link. When exactly one technology qualifies, the resolver writes a synthetic link-partner ability image, raises the auto-negotiation-complete status bit, and keeps the partner-negotiation-able bit of the expansion register at zero.

If both technologies qualify together, the resolver sets a sticky parallel-detection fault and does not resolve a speed. Management software clears the fault by reading the expansion register. If a negotiation ability page is seen while the resolver is watching, the partner can negotiate. The resolver then steps aside and leaves the ability, complete and fault fields as they are. A restart or a disable of auto-negotiation returns the resolver to idle. All pins are plain level or strobe signals: no data streams pass through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pd_parallel_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, lp_ability is 8'h00 and exp_lp_an_able, exp_pd_fault and bmsr_an_complete are 0.
- R2: A technology counts as a good link only after its link flag has been sampled high on qual_cycles consecutive rising edges. Resolution takes effect on the next edge. Any low sample restarts the count. With qual_cycles = 0, a flag that is high is good at once.
- R3: When only the 10 Mb/s link qualifies, lp_ability becomes 8'h21: bit 5 is set, bit 7 is clear, and bits 4:0 hold the selector 5'b00001.
- R4: When only the 100 Mb/s link qualifies, lp_ability becomes 8'h81: bit 7 is set, bit 5 is clear, and bits 4:0 hold 5'b00001.
- R5: bmsr_an_complete rises on the same edge as the ability image. After a completion by parallel detection, exp_lp_an_able reads 0.
- R6: If both links are qualified on the same edge while the resolver is watching, exp_pd_fault is set on that edge. No speed is resolved, bmsr_an_complete stays 0, and watching continues.
- R7: exp_pd_fault stays high until an edge where exp_rd is high and no new fault is being set; it then reads 0 from that edge on. A fault that is set on the same edge as a read wins.
- R8: an_enable low or an_restart high clears bmsr_an_complete, lp_ability, exp_lp_an_able and both qualification counts on the next edge, and puts the resolver in idle. Watching resumes one edge after both controls release.
- R9: page_seen high while watching sets exp_lp_an_able on the next edge. lp_ability, bmsr_an_complete and exp_pd_fault are then left untouched by the links until restart or disable. page_seen takes priority over a link that qualifies on the same edge.
- R10: Once a speed is resolved, later changes on either link flag do not change lp_ability or bmsr_an_complete, and set no fault, until restart or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_restart | input | 1 | Restart request, level |
| page_seen | input | 1 | A negotiation ability page was detected |
| link10_ok | input | 1 | 10 Mb/s receiver reports a valid link signal |
| link100_ok | input | 1 | 100 Mb/s receiver reports a valid link signal |
| qual_cycles | input | CNT_W | Number of consecutive high samples needed to qualify a link |
| exp_rd | input | 1 | Strobe: management read of the expansion register |
| lp_ability | output | 8 | Link-partner ability bits 7:0 (bit 7 = 100 Mb/s, bit 5 = 10 Mb/s, 4:0 = selector) |
| exp_lp_an_able | output | 1 | Expansion bit 0: partner able to negotiate |
| exp_pd_fault | output | 1 | Expansion bit 4: sticky parallel-detection fault |
| bmsr_an_complete | output | 1 | Basic status bit 5: auto-negotiation complete |

## Verification
Each result has a fixed latency. After a link flag rises, with watching active, the ability image and the complete bit appear on rising edge qual_cycles + 1. A dual qualification, a page detection, a restart, a disable and a fault read each show their effect on the very next edge. The bench keeps a cycle-accurate behavioural model that it steps on every rising edge. It compares all four outputs one time unit after that edge, once the registers have settled. Directed checks sample on falling edges, at an exact edge count after each stimulus, and include the cycle just before a result is due, so a result that comes early or late is reported.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WATCH  = 2'd1,
    ST_YIELD  = 2'd2,
    ST_LOCKED = 2'd3
  } pd_state_e;

  localparam int unsigned SPEED_N     = 2;  // index 0: 10 Mb/s, index 1: 100 Mb/s
  localparam int unsigned ABIL_W      = 8;
  localparam int unsigned BIT_10M     = 5;
  localparam int unsigned BIT_100M    = 7;
  localparam logic [4:0]  SEL_IEEE    = 5'b00001;
endpackage

// File: rtl/pd_link_qual.sv
module pd_link_qual #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             link_ok,
  input  logic [CNT_W-1:0] limit,
  output logic             qualified
);
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (clr || !link_ok) begin
      run_cnt <= '0;
    end else if (run_cnt < limit) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign qualified = link_ok && (run_cnt >= limit);

  // R2: a low sample or a clear restarts the run
  p_run_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || !link_ok) |=> (run_cnt == '0));

  // R2: with a non-zero limit, qualification needs an earlier high sample
  p_qual_needs_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (qualified && limit != '0) |-> $past(link_ok));
endmodule

// File: rtl/pd_sticky_flag.sv
module pd_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd_clear,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set)      flag <= 1'b1;
    else if (rd_clear) flag <= 1'b0;
  end

  p_fault_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  p_fault_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !set) |=> !flag);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rd_clear) |=> flag);
endmodule

// File: rtl/pd_resolve_fsm.sv
module pd_resolve_fsm
  import pd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               page_seen,
  input  logic [SPEED_N-1:0] good,
  output logic [ABIL_W-1:0]  lp_ability,
  output logic               an_done,
  output logic               lp_an_able,
  output logic               dual_fault
);
  pd_state_e state_q, state_d;
  logic [ABIL_W-1:0] abil_d;
  logic done_d, able_d;
  logic only10, only100;

  assign only10  = good[0] && !good[1];
  assign only100 = good[1] && !good[0];
  assign dual_fault = (state_q == ST_WATCH) && !clr && !page_seen && (&good);

  always_comb begin
    state_d = state_q;
    abil_d  = lp_ability;
    done_d  = an_done;
    able_d  = lp_an_able;
    if (clr) begin
      state_d = ST_IDLE;
      abil_d  = '0;
      done_d  = 1'b0;
      able_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_WATCH;
        ST_WATCH: begin
          if (page_seen) begin
            state_d = ST_YIELD;
            able_d  = 1'b1;
          end else if (only10 || only100) begin
            state_d          = ST_LOCKED;
            abil_d           = '0;
            abil_d[4:0]      = SEL_IEEE;
            abil_d[BIT_10M]  = only10;
            abil_d[BIT_100M] = only100;
            done_d           = 1'b1;
          end
        end
        ST_YIELD:  state_d = ST_YIELD;
        ST_LOCKED: state_d = ST_LOCKED;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lp_ability <= '0;
      an_done    <= 1'b0;
      lp_an_able <= 1'b0;
    end else begin
      state_q    <= state_d;
      lp_ability <= abil_d;
      an_done    <= done_d;
      lp_an_able <= able_d;
    end
  end

  p_single_speed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lp_ability[BIT_100M], lp_ability[BIT_10M]}));

  p_done_image_r5: assert property (@(posedge clk) disable iff (!rst_n)
    an_done |-> (lp_ability[4:0] == SEL_IEEE && !lp_an_able));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!an_done && lp_ability == '0 && !lp_an_able));

  p_yield_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_YIELD && !clr) |=> ($stable(lp_ability) && $stable(an_done)));

  p_locked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && !clr) |=> ($stable(lp_ability) && an_done));

  p_dual_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_fault && !an_done) |=> !an_done);
endmodule

// File: rtl/pd_parallel_detect.sv
module pd_parallel_detect
  import pd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             an_enable,
  input  logic             an_restart,
  input  logic             page_seen,
  input  logic             link10_ok,
  input  logic             link100_ok,
  input  logic [CNT_W-1:0] qual_cycles,
  input  logic             exp_rd,
  output logic [7:0]       lp_ability,
  output logic             exp_lp_an_able,
  output logic             exp_pd_fault,
  output logic             bmsr_an_complete
);
  logic               clr;
  logic [SPEED_N-1:0] link_vec;
  logic [SPEED_N-1:0] good_vec;
  logic               dual_fault;

  assign clr      = !an_enable || an_restart;
  assign link_vec = {link100_ok, link10_ok};

  for (genvar s = 0; s < SPEED_N; s++) begin : g_qual
    pd_link_qual #(.CNT_W(CNT_W)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .link_ok   (link_vec[s]),
      .limit     (qual_cycles),
      .qualified (good_vec[s])
    );
  end

  pd_resolve_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .page_seen  (page_seen),
    .good       (good_vec),
    .lp_ability (lp_ability),
    .an_done    (bmsr_an_complete),
    .lp_an_able (exp_lp_an_able),
    .dual_fault (dual_fault)
  );

  pd_sticky_flag u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (dual_fault),
    .rd_clear (exp_rd),
    .flag     (exp_pd_fault)
  );

  // R1: fresh out of reset nothing is resolved
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (lp_ability == 8'h00 && !bmsr_an_complete && !exp_pd_fault));
endmodule

// File: tb/pd_parallel_detect_tb.sv
module pd_parallel_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0;
  logic rst_n, an_enable, an_restart, page_seen, link10_ok, link100_ok, exp_rd;
  logic [15:0] qual_cycles;
  logic [7:0] lp_ability;
  logic exp_lp_an_able, exp_pd_fault, bmsr_an_complete;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_parallel_detect u_dut (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .an_restart(an_restart),
    .page_seen(page_seen), .link10_ok(link10_ok), .link100_ok(link100_ok),
    .qual_cycles(qual_cycles), .exp_rd(exp_rd), .lp_ability(lp_ability),
    .exp_lp_an_able(exp_lp_an_able), .exp_pd_fault(exp_pd_fault),
    .bmsr_an_complete(bmsr_an_complete)
  );

  // Behavioural reference: 0 idle, 1 watching, 2 stepped aside, 3 resolved
  int   m_mode = 0;
  int   m_run10 = 0, m_run100 = 0;
  logic [7:0] m_abil = 8'h00;
  logic m_done = 0, m_able = 0, m_fault = 0;

  always @(posedge clk) begin
    int q;
    bit hold, ok10, ok100;
    if (!rst_n) begin
      m_mode = 0; m_run10 = 0; m_run100 = 0;
      m_abil = 8'h00; m_done = 0; m_able = 0; m_fault = 0;
    end else begin
      q     = int'(qual_cycles);
      hold  = !an_enable || an_restart;
      ok10  = link10_ok  && (m_run10  >= q);
      ok100 = link100_ok && (m_run100 >= q);
      if (m_mode == 1 && !hold && !page_seen && ok10 && ok100) m_fault = 1;
      else if (exp_rd) m_fault = 0;
      m_run10  = (hold || !link10_ok)  ? 0 : ((m_run10  < q) ? m_run10 + 1  : m_run10);
      m_run100 = (hold || !link100_ok) ? 0 : ((m_run100 < q) ? m_run100 + 1 : m_run100);
      if (hold) begin
        m_mode = 0; m_abil = 8'h00; m_done = 0; m_able = 0;
      end else if (m_mode == 0) begin
        m_mode = 1;
      end else if (m_mode == 1) begin
        if (page_seen) begin
          m_mode = 2; m_able = 1;
        end else if (ok10 != ok100) begin
          m_mode = 3; m_done = 1;
          m_abil = ok10 ? 8'h21 : 8'h81;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    checks++;
    if ({lp_ability, exp_lp_an_able, exp_pd_fault, bmsr_an_complete} !==
        {m_abil, m_able, m_fault, m_done}) begin
      fails++;
      $display("FAIL %s cycle-model: actual abil=%h able=%b fault=%b done=%b expected abil=%h able=%b fault=%b done=%b",
               cur_req, lp_ability, exp_lp_an_able, exp_pd_fault, bmsr_an_complete,
               m_abil, m_able, m_fault, m_done);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart_pulse();
    an_restart = 1'b1; tick(1);
    an_restart = 1'b0;
  endtask

  task automatic stimulus();
    rst_n = 1'b0; an_enable = 1'b0; an_restart = 1'b0; page_seen = 1'b0;
    link10_ok = 1'b0; link100_ok = 1'b0; exp_rd = 1'b0; qual_cycles = 16'd3;
    tick(3);
    cur_req = "R1";
    chk("R1", "abil in reset", lp_ability, 8'h00);
    chk("R1", "flags in reset", {exp_lp_an_able, exp_pd_fault, bmsr_an_complete}, 3'b000);
    rst_n = 1'b1; tick(1);
    chk("R1", "abil after reset", lp_ability, 8'h00);

    // R3/R2: 10 Mb/s only, qual 3: result due on edge 4
    cur_req = "R3";
    an_enable = 1'b1; link10_ok = 1'b1;
    tick(3);
    chk("R2", "not done before count", bmsr_an_complete, 1'b0);
    tick(1);
    chk("R3", "abil 10M", lp_ability, 8'h21);
    chk("R5", "done with image", bmsr_an_complete, 1'b1);
    chk("R5", "partner-able low", exp_lp_an_able, 1'b0);

    // R10: link changes after lock ignored
    cur_req = "R10";
    link100_ok = 1'b1; tick(6);
    link10_ok = 1'b0; tick(2);
    chk("R10", "abil held", lp_ability, 8'h21);
    chk("R10", "no fault after lock", exp_pd_fault, 1'b0);

    // R8: restart clears
    cur_req = "R8";
    link100_ok = 1'b0;
    restart_pulse();
    chk("R8", "abil cleared", lp_ability, 8'h00);
    chk("R8", "done cleared", bmsr_an_complete, 1'b0);

    // R2/R4: 100 Mb/s with a glitch restarting the count
    cur_req = "R2";
    tick(1);
    link100_ok = 1'b1; tick(2);
    link100_ok = 1'b0; tick(1);
    link100_ok = 1'b1; tick(3);
    chk("R2", "glitch restarted count", bmsr_an_complete, 1'b0);
    tick(1);
    cur_req = "R4";
    chk("R4", "abil 100M", lp_ability, 8'h81);
    chk("R5", "done 100M", bmsr_an_complete, 1'b1);

    // R6/R7: both qualify together
    cur_req = "R6";
    link100_ok = 1'b0;
    restart_pulse(); tick(1);
    link10_ok = 1'b1; link100_ok = 1'b1; tick(4);
    chk("R6", "fault on dual", exp_pd_fault, 1'b1);
    chk("R6", "no done on dual", bmsr_an_complete, 1'b0);
    chk("R6", "no abil on dual", lp_ability, 8'h00);
    cur_req = "R7";
    exp_rd = 1'b1; tick(1);
    exp_rd = 1'b0;
    chk("R7", "set wins over read", exp_pd_fault, 1'b1);
    link100_ok = 1'b0; tick(2);
    chk("R7", "fault sticky", exp_pd_fault, 1'b1);
    chk("R6", "resolved after dual ends", lp_ability, 8'h21);
    exp_rd = 1'b1; tick(1);
    exp_rd = 1'b0;
    chk("R7", "read clears", exp_pd_fault, 1'b0);

    // R9: page wins and freezes fields
    cur_req = "R9";
    link10_ok = 1'b0;
    restart_pulse(); tick(1);
    page_seen = 1'b1; link10_ok = 1'b1; tick(1);
    page_seen = 1'b0;
    chk("R9", "partner able set", exp_lp_an_able, 1'b1);
    link100_ok = 1'b1; tick(6);
    chk("R9", "abil untouched", lp_ability, 8'h00);
    chk("R9", "done untouched", bmsr_an_complete, 1'b0);
    chk("R9", "fault untouched", exp_pd_fault, 1'b0);

    // R8: disable clears and blocks; R2 with qual 0
    cur_req = "R8";
    an_enable = 1'b0; link100_ok = 1'b0; tick(1);
    chk("R8", "able cleared on disable", exp_lp_an_able, 1'b0);
    tick(5);
    chk("R8", "disabled stays idle", bmsr_an_complete, 1'b0);
    cur_req = "R2";
    qual_cycles = 16'd0; an_enable = 1'b1; tick(2);
    chk("R2", "qual zero resolves", lp_ability, 8'h21);

    // R1: reset mid-operation
    cur_req = "R1";
    rst_n = 1'b0; tick(1);
    chk("R1", "reset clears lock", {lp_ability, bmsr_an_complete}, 9'h000);
    rst_n = 1'b1; link10_ok = 1'b0; tick(3);
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule